// File: doc/BRIEF.md
# Receive Descriptor Ring Write Engine

This block takes received Ethernet frames as a stream of 32-bit words and places them in system memory through a ring of descriptors. Each descriptor is two words, eight bytes in all. Word 0 holds the address of a 128-byte buffer, an ownership flag in bit 0 and an end-of-ring flag in bit 1. Word 1 holds receive status. A frame longer than one buffer continues into the next descriptors of the ring. Each descriptor the block fills is handed to software by setting its ownership flag.

The address filter lies outside this block. Its results come in beside the last word of each frame and are copied into the status word of the descriptor that closes the frame. If the block needs a descriptor that software still owns, it drops the rest of the frame and pulses an overrun output. The ring pointer then stays on that descriptor, so reception resumes there once software frees it.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, `in_ready`, `mem_en` and `ovr_o` are all low until a frame word is offered.
- R2: Before it uses a descriptor, the block reads its word 0 at the ring pointer. The buffer address is that word with bits 1:0 cleared.
- R3: Frame bytes are stored little-endian, frame byte 4n+j going to byte lane j of buffer word n. On the last word, `in_nbytes` gives the valid byte count (0 means 4), and only those lanes are enabled. Buffer bytes past the end of the frame keep their old contents.
- R4: Once 128 bytes of a frame fill a buffer, the frame continues at byte 0 of the next descriptor's buffer.
- R5: In the status word, bit 14 is set only in a frame's first descriptor and bit 15 only in its last. Bits 11:0 carry the total frame length in bytes, and only in the last descriptor. Also only in the last descriptor, `in_addr_hit[k]` goes to bit 26-k, `in_type_hit` to bit 22 and `in_bcast` to bit 31. These match inputs are sampled with the last word. All other bits are 0.
- R6: After a buffer is done, word 0 of its descriptor is rewritten with bit 0 set. The buffer address and bit 1 are kept.
- R7: A descriptor's data writes come first. The status write at descriptor address +4 follows in the next cycle, then the ownership write to word 0 in the cycle after that.
- R8: After a descriptor whose bit 1 is set, the pointer returns to `RING_BASE`. Otherwise it advances by 8.
- R9: If the descriptor needed for a frame's first buffer is owned, `ovr_o` pulses for one cycle. The whole frame is then consumed with no memory write, and the pointer does not move.
- R10: If a descriptor needed in the middle of a frame is owned, the descriptors already written stay owned, with bit 15 clear. The rest of the frame is discarded, and the next frame starts at that owned descriptor once it is freed.
- R11: A word is taken only in a cycle where both `in_valid` and `in_ready` are high. The block never reads memory in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Frame word offered |
| in_ready | output | 1 | Frame word accepted this cycle |
| in_data | input | 32 | Frame bytes, little-endian |
| in_last | input | 1 | Last word of frame |
| in_nbytes | input | 2 | Valid bytes in the last word, 0 meaning 4 |
| in_addr_hit | input | 4 | Specific-address match flags, sampled with the last word |
| in_type_hit | input | 1 | Type-ID match, sampled with the last word |
| in_bcast | input | 1 | Broadcast flag, sampled with the last word |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane write enables |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| ovr_o | output | 1 | Overrun pulse: a needed descriptor was owned |

## Verification
The assertions assume memory accepts every access at once and returns read data exactly one cycle after a read. They also assume `in_last` marks exactly one word per frame, and that software changes descriptors only between frames. The bench's memory model answers in a fixed cycle. It frees or claims descriptors only while the stream is idle and the block has finished its ownership write. Frames are offered with a valid-ready handshake that holds each word until it is taken.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_DATA, S_STAT, S_OWN, S_DROP
  } rxd_state_e;

  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 12;

  // byte lanes enabled in a frame's final word; 0 encodes a full word
  function automatic logic [3:0] tail_lanes(input logic [1:0] nb);
    case (nb)
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [2:0] word_bytes(input logic last, input logic [1:0] nb);
    return (last && nb != 2'd0) ? {1'b0, nb} : 3'd4;
  endfunction

  // descriptor word 0 after hand-off: address kept, end-of-ring kept, owned
  function automatic logic [31:0] owned_word(input logic [31:0] base, input logic ring_end);
    return {base[31:2], ring_end, 1'b1};
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter logic [31:0] RING_BASE = 32'h0000_0100,
  parameter int          STEP      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        ring_end,
  output logic [31:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= RING_BASE;
    else if (adv)   ptr <= ring_end ? RING_BASE : ptr + 32'(STEP);
  end
endmodule

// File: rtl/rxd_fill_ctr.sv
module rxd_fill_ctr #(
  parameter int BUF_WORDS = 32,
  parameter int LEN_W     = 12,
  localparam int WCW      = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             buf_clr,
  input  logic             step,
  input  logic [2:0]       step_bytes,
  output logic [WCW-1:0]   word_idx,
  output logic             buf_last,
  output logic [LEN_W-1:0] frame_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_idx  <= '0;
      frame_len <= '0;
    end else begin
      if (buf_clr)      word_idx <= '0;
      else if (step)    word_idx <= word_idx + 1'b1;
      if (frame_clr)    frame_len <= '0;
      else if (step)    frame_len <= frame_len + LEN_W'(step_bytes);
    end
  end
  assign buf_last = (word_idx == WCW'(BUF_WORDS - 1));
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt #(
  parameter int LEN_W = 12,
  parameter int N_HIT = 4
) (
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] len,
  input  logic [N_HIT-1:0] addr_hit,
  input  logic             type_hit,
  input  logic             bcast,
  output logic [31:0]      word
);
  logic [N_HIT-1:0] hit_field;
  // address register k+1 lands at bit 26-k: reverse lanes into the field
  for (genvar k = 0; k < N_HIT; k++) begin : g_hit
    assign hit_field[N_HIT-1-k] = eof & addr_hit[k];
  end
  always_comb begin
    word        = '0;
    word[11:0]  = eof ? 12'(len) : 12'd0;
    word[14]    = sof;
    word[15]    = eof;
    word[22]    = eof & type_hit;
    word[26:23] = hit_field;
    word[31]    = eof & bcast;
  end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
  parameter logic [31:0] RING_BASE = 32'h0000_0100,
  parameter int          BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic [1:0]  in_nbytes,
  input  logic [3:0]  in_addr_hit,
  input  logic        in_type_hit,
  input  logic        in_bcast,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  output logic        ovr_o
);
  import rxd_pkg::*;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WCW       = $clog2(BUF_WORDS);

  rxd_state_e       st;
  logic [31:0]      ptr, buf_base, stat_word;
  logic             ring_end_q, first_q, eof_q, type_q, bc_q;
  logic [3:0]       hit_q;
  logic [WCW-1:0]   word_idx;
  logic             buf_last;
  logic [LEN_W-1:0] frame_len;

  // named events for the checker
  logic ev_data_wr, ev_stat_wr, ev_own_wr, ev_owned_seen;
  assign ev_data_wr    = (st == S_DATA) && in_valid;
  assign ev_stat_wr    = (st == S_STAT);
  assign ev_own_wr     = (st == S_OWN);
  assign ev_owned_seen = (st == S_CHECK) && mem_rdata[0];

  rxd_ring_ptr #(.RING_BASE(RING_BASE), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(ev_own_wr), .ring_end(ring_end_q), .ptr(ptr));

  rxd_fill_ctr #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .frame_clr(st == S_IDLE), .buf_clr(st == S_CHECK),
    .step(ev_data_wr), .step_bytes(word_bytes(in_last, in_nbytes)),
    .word_idx(word_idx), .buf_last(buf_last), .frame_len(frame_len));

  rxd_status_fmt #(.LEN_W(LEN_W), .N_HIT(4)) u_fmt (
    .sof(first_q), .eof(eof_q), .len(frame_len), .addr_hit(hit_q),
    .type_hit(type_q), .bcast(bc_q), .word(stat_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; buf_base <= '0; ring_end_q <= 1'b0; first_q <= 1'b1;
      eof_q <= 1'b0; hit_q <= '0; type_q <= 1'b0; bc_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          first_q <= 1'b1;
          if (in_valid) st <= S_FETCH;
        end
        S_FETCH: st <= S_CHECK;
        S_CHECK: begin
          if (mem_rdata[0]) st <= S_DROP;
          else begin
            buf_base   <= {mem_rdata[31:2], 2'b00};
            ring_end_q <= mem_rdata[1];
            st         <= S_DATA;
          end
        end
        S_DATA: if (in_valid) begin
          if (in_last) begin
            eof_q <= 1'b1; hit_q <= in_addr_hit; type_q <= in_type_hit; bc_q <= in_bcast;
            st <= S_STAT;
          end else if (buf_last) begin
            eof_q <= 1'b0;
            st <= S_STAT;
          end
        end
        S_STAT: st <= S_OWN;
        S_OWN: begin
          first_q <= 1'b0;
          st <= eof_q ? S_IDLE : S_FETCH;
        end
        S_DROP: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = ptr; mem_wdata = '0; mem_be = 4'h0;
    case (st)
      S_FETCH: mem_en = 1'b1;
      S_DATA: begin
        mem_en    = in_valid;
        mem_we    = in_valid;
        mem_addr  = buf_base | {{(32-WCW-2){1'b0}}, word_idx, 2'b00};
        mem_wdata = in_data;
        mem_be    = in_valid ? (in_last ? tail_lanes(in_nbytes) : 4'hF) : 4'h0;
      end
      S_STAT: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = ptr + 32'd4;
        mem_wdata = stat_word; mem_be = 4'hF;
      end
      S_OWN: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_wdata = owned_word(buf_base, ring_end_q); mem_be = 4'hF;
      end
      default: ;
    endcase
  end

  assign in_ready = (st == S_DATA) || (st == S_DROP);
  assign ovr_o    = ev_owned_seen;
endmodule

// File: rtl/rxd_ring_chk.sv
module rxd_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        mem_en,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        ovr_o,
  input logic        ev_data_wr,
  input logic        ev_stat_wr,
  input logic        ev_own_wr
);
  // R7
  stat_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> $past(ev_data_wr));
  // R7
  own_after_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> $past(ev_stat_wr));
  // R6
  own_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_wr |-> mem_wdata[0]);
  // R9
  no_write_after_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> !mem_en);
  // R11
  no_read_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && mem_en && !mem_we));
  // R3
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_be != 4'h0));
endmodule

bind rxd_ring_writer rxd_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_en(mem_en), .mem_we(mem_we),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .ovr_o(ovr_o), .ev_data_wr(ev_data_wr),
  .ev_stat_wr(ev_stat_wr), .ev_own_wr(ev_own_wr));

// File: tb/sim_rxd_ring_writer.sv
module sim_rxd_ring_writer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, in_last = 1'b0, in_type_hit = 1'b0, in_bcast = 1'b0;
  logic [31:0] in_data = '0, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  in_nbytes = '0;
  logic [3:0]  in_addr_hit = '0, mem_be;
  logic        mem_en, mem_we, ovr_o;
  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0, ovr_cnt = 0, dptr = 0;

  always #10 clk = ~clk;

  rxd_ring_writer u0 (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(negedge clk) if (ovr_o) ovr_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input int i);
    return 8'((k * 37 + i * 7 + 3) & 255);
  endfunction
  function automatic int bufw(input int d);  // word index of buffer start
    return (32'h200 + d * 128) / 4;
  endfunction
  function automatic logic [31:0] w0(input int d, input bit used);
    return 32'h200 + d * 128 + ((d == 3) ? 2 : 0) + (used ? 1 : 0);
  endfunction

  task automatic free_desc(input int d, input bit used);
    mem[32'h100 / 4 + 2 * d]     = w0(d, used);
    mem[32'h100 / 4 + 2 * d + 1] = '0;
    for (int w = 0; w < 32; w++) mem[bufw(d) + w] = 32'hA5A5_A5A5;
  endtask

  task automatic send(input int k, input int len);
    int nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int b = 0; b < 4; b++) in_data[8*b +: 8] = fbyte(k, 4 * w + b);
      in_last     = (w == nw - 1);
      in_nbytes   = 2'(len % 4);
      in_addr_hit = in_last ? 4'((k * 5) & 15) : ~4'((k * 5) & 15);
      in_type_hit = in_last ? k[0] : ~k[0];
      in_bcast    = in_last ? k[1] : ~k[1];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // verify a frame stored from descriptor dptr, then release its descriptors
  task automatic verify(input int k, input int len);
    int nbuf = (len + 127) / 128;
    int bad = 0;
    logic [31:0] st_exp;
    for (int i = 0; i < len; i++) begin
      int d = (dptr + i / 128) % 4;
      int wi = bufw(d) + (i % 128) / 4;
      if (mem[wi][8 * (i % 4) +: 8] !== fbyte(k, i)) bad++;
    end
    chk(bad == 0, "R3/R4 data bytes", 32'(bad), 0);
    if (len % 4 != 0) begin
      int d = (dptr + (len - 1) / 128) % 4;
      int wi = bufw(d) + ((len - 1) % 128) / 4;
      int bb = 0;
      for (int b = len % 4; b < 4; b++) if (mem[wi][8*b +: 8] !== 8'hA5) bb++;
      chk(bb == 0, "R3 unused lanes untouched", mem[wi], 32'hA5A5_A5A5);
    end
    for (int b = 0; b < nbuf; b++) begin
      int d = (dptr + b) % 4;
      st_exp = '0;
      st_exp[14] = (b == 0);
      if (b == nbuf - 1) begin
        st_exp[15] = 1'b1;
        st_exp[11:0] = 12'(len);
        for (int h = 0; h < 4; h++) st_exp[26 - h] = ((k * 5) >> h) & 1;
        st_exp[22] = k[0];
        st_exp[31] = k[1];
      end
      chk(mem[32'h100/4 + 2*d + 1] === st_exp, "R5 status word", mem[32'h100/4 + 2*d + 1], st_exp);
      chk(mem[32'h100/4 + 2*d] === w0(d, 1), "R6/R8 owned word0", mem[32'h100/4 + 2*d], w0(d, 1));
      free_desc(d, 0);
    end
    dptr = (dptr + nbuf) % 4;
  endtask

  initial begin
    int lens[13] = '{1, 2, 3, 4, 5, 127, 128, 129, 255, 256, 257, 300, 512};
    int o0;
    for (int a = 0; a < 1024; a++) mem[a] = '0;
    for (int d = 0; d < 4; d++) free_desc(d, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready === 1'b0 && mem_en === 1'b0 && ovr_o === 1'b0, "R1 reset outputs",
        {29'd0, in_ready, mem_en, ovr_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready === 1'b0 && mem_en === 1'b0, "R1 idle after reset", {30'd0, in_ready, mem_en}, 0);
    // R2/R3/R4/R5/R6/R8/R11: length sweep, wraps the four-entry ring several times
    for (int n = 0; n < 13; n++) begin
      send(n, lens[n]);
      verify(n, lens[n]);
    end
    chk(ovr_cnt == 0, "R9 no overrun while ring free", 32'(ovr_cnt), 0);
    // R9: owned descriptor at frame start
    for (int d = 0; d < 4; d++) free_desc(d, 1);
    o0 = ovr_cnt;
    send(20, 40);
    chk(ovr_cnt == o0 + 1, "R9 overrun pulse at start", 32'(ovr_cnt - o0), 1);
    chk(mem[32'h100/4 + 2*dptr + 1] === 0 && mem[bufw(dptr)] === 32'hA5A5_A5A5,
        "R9 nothing written", mem[bufw(dptr)], 32'hA5A5_A5A5);
    for (int d = 0; d < 4; d++) free_desc(d, 0);
    send(21, 10);
    verify(21, 10);  // R9: pointer did not move
    // R10: owned descriptor in the middle of a frame
    free_desc((dptr + 1) % 4, 1);
    o0 = ovr_cnt;
    send(22, 200);
    chk(ovr_cnt == o0 + 1, "R10 overrun pulse mid-frame", 32'(ovr_cnt - o0), 1);
    chk(mem[32'h100/4 + 2*dptr + 1] === 32'h0000_4000, "R10 first part kept, no end flag",
        mem[32'h100/4 + 2*dptr + 1], 32'h0000_4000);
    chk(mem[32'h100/4 + 2*dptr] === w0(dptr, 1), "R10 first part owned",
        mem[32'h100/4 + 2*dptr], w0(dptr, 1));
    free_desc(dptr, 0);
    dptr = (dptr + 1) % 4;
    free_desc(dptr, 0);
    send(23, 60);
    verify(23, 60);  // R10: resumes at the descriptor that was owned
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule